// File: doc/BRIEF.md
# Scan-List Conversion Sequencer

This block walks through a list of channel entries loaded by a host and sends one conversion-start strobe for each entry. The strobe carries that entry's channel, gain code, differential flag and external-mux fields. Each entry also holds a start bit. An entry with the start bit set waits for a tick from a programmable 24-bit pacer. An entry without it follows the previous conversion after a fixed burst gap. A list with the start bit on every entry therefore paces each conversion. A list with the start bit only on its first entry paces whole scans and fires the remaining entries back to back.

The host loads entries as byte pairs through a shared byte bus, sets the pacer reload value in byte lanes, and chooses the pacer clock source and the burst code. It then arms the sequencer. In one-shot mode the list runs once per arm. In continuous mode the list wraps until a stop command or a queue clear. The block does not contain the converter, the analog mux or the sample FIFO.

Top module: `scan_sequencer`

## Requirements
- R1: An entry is taken from two `entryWr` byte writes on `wrData`, low byte first. In the resulting 16-bit word, bit 14 is differential, bits 13:12 are gain, bits 11:8 are channel, bit 7 is start, bits 5:4 are external gain and bits 3:0 are external channel. Bits 15 and 6 are ignored.
- R2: An entry with the start bit set is issued on the first pacer tick while it is current. After arm, the pacer ticks every (reload+1) source ticks. The conversion strobe follows the tick cycle by one cycle.
- R3: An entry without the start bit is issued a burst gap of BURST_BASE, 2*BURST_BASE or 4*BURST_BASE cycles after the previous strobe, for `burstCode` 0, 1 or 2 (code 3 acts like 2). If such an entry comes first after arm, its strobe appears in the second cycle after arm.
- R4: `clkSrc` selects the pacer source tick. Value 0 uses the `extTick` input. Values 1, 2 and 3 divide the system clock by DIV_FAST, DIV_MID and DIV_SLOW, counted from arm.
- R5: In one-shot mode (`contMode`=0) the list runs once, and `running` drops in the same cycle as the strobe of the last entry.
- R6: In continuous mode the list wraps to entry 0 and repeats. `stop` clears `running` on the next cycle, and no strobe follows it.
- R7: `endOfScan` is high together with the strobe of the last loaded entry, and at no other time.
- R8: `queueClr` empties the list, drops a half-written entry and halts the sequencer on the next cycle.
- R9: The list holds DEPTH entries. Entry writes beyond that are ignored.
- R10: `arm` is ignored while the sequencer is running or while the list is empty.
- R11: After reset, `running`, `convStrobe` and `endOfScan` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 8 | Shared host write byte |
| entryWr | input | 1 | Write `wrData` as the next entry byte |
| queueClr | input | 1 | Empty the list and halt |
| pacerWr | input | 1 | Write `wrData` into the pacer reload lane `pacerSel` |
| pacerSel | input | 2 | Pacer lane: 0 low, 1 mid, 2 high |
| clkSrc | input | 2 | Pacer source: 0 external, 1 fast, 2 mid, 3 slow |
| extTick | input | 1 | External source tick, one cycle per tick |
| burstCode | input | 2 | Burst gap select |
| contMode | input | 1 | 1 = continuous, 0 = one-shot |
| arm | input | 1 | Start a run from entry 0 |
| stop | input | 1 | Halt the run |
| convStrobe | output | 1 | One-cycle conversion start |
| convChan | output | 4 | Channel of the issued entry |
| convGain | output | 2 | Gain code of the issued entry |
| convDiff | output | 1 | Differential flag of the issued entry |
| convExtChan | output | 4 | External channel of the issued entry |
| convExtGain | output | 2 | External gain of the issued entry |
| endOfScan | output | 1 | High with the strobe of the last entry |
| running | output | 1 | Sequencer active |

## Verification
The assertions assume that the host commands are single-cycle pulses driven between clock edges. They also assume that `contMode` only changes while the sequencer is idle, since the one-shot check uses the mode seen at the final issue. The stimulus drives every input on the falling edge and changes the mode and source selects only before an arm. It ends each continuous run with either `stop` or `queueClr`. Pacer reload values and burst codes are chosen so that the strobe cycles can be predicted exactly from the arm cycle.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef struct packed {
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic       start;
    logic [1:0] extGain;
    logic [3:0] extChan;
  } scan_entry_t;

  typedef struct packed {
    logic run;      // level: sequencer active
    logic restart;  // arm accepted this cycle
    logic issue;    // current entry issued this cycle
    logic last;     // issued entry is the final one
  } seq_strobe_t;

  // lo = {b7, b5..b0} of the low byte, hi = b6..b0 of the high byte
  function automatic scan_entry_t unpack_entry(input logic [6:0] lo, input logic [6:0] hi);
    scan_entry_t e;
    e.diff    = hi[6];
    e.gain    = hi[5:4];
    e.chan    = hi[3:0];
    e.start   = lo[6];
    e.extGain = lo[5:4];
    e.extChan = lo[3:0];
    return e;
  endfunction

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          arm,
  input  logic          stop,
  input  logic          queueClr,
  input  logic          contMode,
  input  logic          curStart,
  input  logic          pacerTick,
  input  logic          burstReady,
  input  logic [CW-1:0] listCount,
  output logic [AW-1:0] idx,
  output logic          running,
  output seq_strobe_t   ctl
);

  logic halt, atLast, armOk, fire;

  assign halt   = stop | queueClr;
  assign atLast = (CW'(idx) == (listCount - CW'(1)));
  assign armOk  = arm & ~running & (listCount != '0) & ~halt;
  assign fire   = running & ~halt & (curStart ? pacerTick : burstReady);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (halt) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (armOk) begin
      running <= 1'b1;
      idx     <= '0;
    end else if (fire) begin
      if (atLast) begin
        idx <= '0;
        if (!contMode) running <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign ctl.run     = running;
  assign ctl.restart = armOk;
  assign ctl.issue   = fire;
  assign ctl.last    = fire & atLast;

endmodule

// File: rtl/scan_seq_datapath.sv
module scan_seq_datapath
  import scan_seq_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int AW         = 11,
  parameter int CW         = 12,
  parameter int PACER_W    = 24,
  parameter int SEL_W      = 2,
  parameter int DIV_FAST   = 10,
  parameter int DIV_MID    = 50,
  parameter int DIV_SLOW   = 500,
  parameter int BURST_BASE = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      ctl,
  input  logic [AW-1:0]    idx,
  input  logic [7:0]       wrData,
  input  logic             entryWr,
  input  logic             queueClr,
  input  logic             pacerWr,
  input  logic [SEL_W-1:0] pacerSel,
  input  logic [1:0]       clkSrc,
  input  logic             extTick,
  input  logic [1:0]       burstCode,
  output logic             curStart,
  output logic             pacerTick,
  output logic             burstReady,
  output logic [CW-1:0]    listCount,
  output logic             convStrobe,
  output logic             endOfScan,
  output scan_entry_t      convEntry
);

  localparam int PACER_LANES = PACER_W / 8;
  localparam int PRE_W = $clog2(DIV_SLOW + 1);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(DIV_MID - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);
  localparam int BW = $clog2(BURST_BASE * 4 + 1);
  localparam logic [BW-1:0] GAP_1 = BW'(BURST_BASE - 1);
  localparam logic [BW-1:0] GAP_2 = BW'(BURST_BASE * 2 - 1);
  localparam logic [BW-1:0] GAP_4 = BW'(BURST_BASE * 4 - 1);

  // ---------------- entry list ----------------
  scan_entry_t listMem [DEPTH];
  logic [6:0]  lowHeld;
  logic        phaseHi;
  logic        listFull;
  scan_entry_t curEntry;

  assign listFull = (listCount == CW'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHi   <= 1'b0;
      lowHeld   <= '0;
      listCount <= '0;
    end else if (queueClr) begin
      phaseHi   <= 1'b0;
      listCount <= '0;
    end else if (entryWr) begin
      if (!phaseHi) begin
        lowHeld <= {wrData[7], wrData[5:0]};
        phaseHi <= 1'b1;
      end else begin
        phaseHi <= 1'b0;
        if (!listFull) listCount <= listCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!queueClr && entryWr && phaseHi && !listFull)
      listMem[listCount[AW-1:0]] <= unpack_entry(lowHeld, wrData[6:0]);
  end

  assign curEntry = listMem[idx];
  assign curStart = curEntry.start;

  // ---------------- pacer reload lanes ----------------
  logic [PACER_W-1:0] pacerReload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pacerReload <= '0;
    end else if (pacerWr) begin
      for (int b = 0; b < PACER_LANES; b++)
        if (pacerSel == SEL_W'(b)) pacerReload[8*b +: 8] <= wrData;
    end
  end

  // ---------------- source prescaler ----------------
  logic [PRE_W-1:0] preCnt, preLim;
  logic             internalSrc, preWrap, srcTick;

  always_comb begin
    case (clkSrc)
      2'd1:    preLim = LIM_FAST;
      2'd2:    preLim = LIM_MID;
      default: preLim = LIM_SLOW;
    endcase
  end

  assign internalSrc = (clkSrc != 2'd0);
  assign preWrap     = (preCnt >= preLim);
  assign srcTick     = ctl.run & (internalSrc ? preWrap : extTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        preCnt <= '0;
    else if (ctl.restart)             preCnt <= '0;
    else if (ctl.run && internalSrc)  preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  // ---------------- pacer down-counter ----------------
  logic [PACER_W-1:0] pacerCnt;

  assign pacerTick = srcTick & (pacerCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pacerCnt <= '0;
    else if (ctl.restart) pacerCnt <= pacerReload;
    else if (srcTick)     pacerCnt <= (pacerCnt == '0) ? pacerReload : pacerCnt - 1'b1;
  end

  // ---------------- burst spacing ----------------
  logic [BW-1:0] burstCnt, burstLim;

  always_comb begin
    case (burstCode)
      2'd0:    burstLim = GAP_1;
      2'd1:    burstLim = GAP_2;
      default: burstLim = GAP_4;
    endcase
  end

  assign burstReady = (burstCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                burstCnt <= '0;
    else if (ctl.restart)     burstCnt <= '0;
    else if (ctl.issue)       burstCnt <= burstLim;
    else if (burstCnt != '0)  burstCnt <= burstCnt - 1'b1;
  end

  // ---------------- conversion outputs ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStrobe <= 1'b0;
      endOfScan  <= 1'b0;
      convEntry  <= '0;
    end else begin
      convStrobe <= ctl.issue;
      endOfScan  <= ctl.last;
      if (ctl.issue) convEntry <= curEntry;
    end
  end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int PACER_W    = 24,
  parameter int DIV_FAST   = 10,
  parameter int DIV_MID    = 50,
  parameter int DIV_SLOW   = 500,
  parameter int BURST_BASE = 500,
  localparam int LIST_AW   = $clog2(DEPTH),
  localparam int LIST_CW   = $clog2(DEPTH + 1),
  localparam int SEL_W     = $clog2(PACER_W / 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       wrData,
  input  logic             entryWr,
  input  logic             queueClr,
  input  logic             pacerWr,
  input  logic [SEL_W-1:0] pacerSel,
  input  logic [1:0]       clkSrc,
  input  logic             extTick,
  input  logic [1:0]       burstCode,
  input  logic             contMode,
  input  logic             arm,
  input  logic             stop,
  output logic             convStrobe,
  output logic [3:0]       convChan,
  output logic [1:0]       convGain,
  output logic             convDiff,
  output logic [3:0]       convExtChan,
  output logic [1:0]       convExtGain,
  output logic             endOfScan,
  output logic             running
);

  seq_strobe_t        ctl;
  logic [LIST_AW-1:0] idx;
  logic [LIST_CW-1:0] listCount;
  logic               curStart, pacerTick, burstReady;
  scan_entry_t        convEntry;

  scan_seq_ctrl #(.AW(LIST_AW), .CW(LIST_CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .arm(arm), .stop(stop), .queueClr(queueClr),
    .contMode(contMode), .curStart(curStart), .pacerTick(pacerTick),
    .burstReady(burstReady), .listCount(listCount), .idx(idx),
    .running(running), .ctl(ctl)
  );

  scan_seq_datapath #(
    .DEPTH(DEPTH), .AW(LIST_AW), .CW(LIST_CW), .PACER_W(PACER_W), .SEL_W(SEL_W),
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .BURST_BASE(BURST_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .wrData(wrData),
    .entryWr(entryWr), .queueClr(queueClr), .pacerWr(pacerWr), .pacerSel(pacerSel),
    .clkSrc(clkSrc), .extTick(extTick), .burstCode(burstCode),
    .curStart(curStart), .pacerTick(pacerTick), .burstReady(burstReady),
    .listCount(listCount), .convStrobe(convStrobe), .endOfScan(endOfScan),
    .convEntry(convEntry)
  );

  assign convChan    = convEntry.chan;
  assign convGain    = convEntry.gain;
  assign convDiff    = convEntry.diff;
  assign convExtChan = convEntry.extChan;
  assign convExtGain = convEntry.extGain;

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic arm,
  input logic stop,
  input logic queueClr,
  input logic contMode,
  input logic convStrobe,
  input logic endOfScan,
  input logic running
);

  // R7
  eos_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    endOfScan |-> convStrobe);

  // R6
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!running && !convStrobe));

  // R8
  clear_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueClr |=> (!running && !convStrobe));

  // R5
  oneshot_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endOfScan && !$past(contMode)) |-> !running);

  // R2
  strobe_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |-> $past(running));

  // R10
  arm_idle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arm && running && !stop && !queueClr) |=> running);

endmodule

bind scan_sequencer scan_sequencer_chk chk_i (
  .clk(clk), .rstN(rstN), .arm(arm), .stop(stop), .queueClr(queueClr),
  .contMode(contMode), .convStrobe(convStrobe), .endOfScan(endOfScan),
  .running(running)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       entryWr = 1'b0, queueClr = 1'b0, pacerWr = 1'b0;
  logic [1:0] pacerSel = '0, clkSrc = 2'd1, burstCode = '0;
  logic       extTick = 1'b0, contMode = 1'b0, arm = 1'b0, stop = 1'b0;
  logic       convStrobe, convDiff, endOfScan, running;
  logic [3:0] convChan, convExtChan;
  logic [1:0] convGain, convExtGain;

  always #10 clk = ~clk;  // 50 MHz

  scan_sequencer #(
    .DEPTH(8), .PACER_W(24), .DIV_FAST(2), .DIV_MID(3), .DIV_SLOW(5), .BURST_BASE(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .entryWr(entryWr), .queueClr(queueClr),
    .pacerWr(pacerWr), .pacerSel(pacerSel), .clkSrc(clkSrc), .extTick(extTick),
    .burstCode(burstCode), .contMode(contMode), .arm(arm), .stop(stop),
    .convStrobe(convStrobe), .convChan(convChan), .convGain(convGain),
    .convDiff(convDiff), .convExtChan(convExtChan), .convExtGain(convExtGain),
    .endOfScan(endOfScan), .running(running)
  );

  typedef struct {
    logic [15:0] word;
    logic        eos;
    int          k;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   armCyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int kNow();
    return cyc - armCyc + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic expectConv(input logic [15:0] w, input logic eos, input int k, input string tag);
    exp_t e;
    e.word = w; e.eos = eos; e.k = k; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rstN && convStrobe) begin
      if (q.size() == 0) begin
        check(1'b0, "R6", "unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        logic [14:0] act, expv;
        e = q.pop_front();
        act  = {convDiff, convGain, convChan, convExtGain, convExtChan};
        expv = {e.word[14], e.word[13:12], e.word[11:8], e.word[5:4], e.word[3:0]};
        check(act == expv, e.tag, "fields", act, expv);
        check(endOfScan == e.eos, "R7", "endOfScan", endOfScan, e.eos);
        check(kNow() == e.k, e.tag, "strobe cycle", kNow(), e.k);
      end
    end
  end

  task automatic busWrite(input logic [7:0] d, input bit toEntry, input logic [1:0] sel);
    @(negedge clk);
    wrData = d; pacerSel = sel;
    entryWr = toEntry; pacerWr = !toEntry;
    @(negedge clk);
    entryWr = 1'b0; pacerWr = 1'b0;
  endtask

  task automatic writeEntry(input logic [15:0] w);
    busWrite(w[7:0], 1'b1, 2'd0);
    busWrite(w[15:8], 1'b1, 2'd0);
  endtask

  task automatic setPacer(input logic [23:0] v);
    for (int b = 0; b < 3; b++) busWrite(v[8*b +: 8], 1'b0, 2'(b));
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic armNow();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    armCyc = cyc;
  endtask

  task automatic waitK(input int k);
    while (kNow() < k) @(negedge clk);
  endtask

  task automatic idleCheck(input int cycles, input string tag);
    repeat (cycles) @(negedge clk);
    check(running == 1'b0, tag, "running idle", running, 0);
    check(q.size() == 0, tag, "missing strobes", q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(running == 0 && convStrobe == 0 && endOfScan == 0, "R11", "reset outputs",
          {running, convStrobe, endOfScan}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(running == 0 && convStrobe == 0, "R11", "after reset", {running, convStrobe}, 0);

    // Per-conversion pacing, one-shot, fast source, reload 2 (R1 R2 R4 R5 R10)
    writeEntry(16'h4A85);
    writeEntry(16'h3180);
    writeEntry(16'h72BF);
    writeEntry(16'hC5C3);   // R1: bits 15 and 6 ignored
    setPacer(24'd2);
    clkSrc = 2'd1; contMode = 1'b0;
    expectConv(16'h4A85, 1'b0, 7,  "R2");
    expectConv(16'h3180, 1'b0, 13, "R2");
    expectConv(16'h72BF, 1'b0, 19, "R1");
    expectConv(16'hC5C3, 1'b1, 25, "R1");
    armNow();
    waitK(9);
    pulse(arm);             // R10: arm while running has no effect
    idleCheck(30, "R5");

    // Per-scan pacing, continuous, slow source, burst code 1 (R3 R4 R6 R7)
    pulse(queueClr);
    writeEntry(16'h0380);
    writeEntry(16'h1400);
    writeEntry(16'h6920);
    setPacer(24'd3);
    clkSrc = 2'd3; burstCode = 2'd1; contMode = 1'b1;
    expectConv(16'h0380, 1'b0, 21, "R4");
    expectConv(16'h1400, 1'b0, 29, "R3");
    expectConv(16'h6920, 1'b1, 37, "R7");
    expectConv(16'h0380, 1'b0, 41, "R6");
    expectConv(16'h1400, 1'b0, 49, "R3");
    expectConv(16'h6920, 1'b1, 57, "R6");
    armNow();
    waitK(58);
    pulse(stop);
    idleCheck(40, "R6");

    // Burst-only list: codes 2, 3 and 0 (R3)
    pulse(queueClr);
    writeEntry(16'h0700);
    writeEntry(16'h2B11);
    contMode = 1'b0; clkSrc = 2'd1; burstCode = 2'd2;
    expectConv(16'h0700, 1'b0, 2, "R3");
    expectConv(16'h2B11, 1'b1, 18, "R3");
    armNow();
    idleCheck(25, "R3");
    burstCode = 2'd3;
    expectConv(16'h0700, 1'b0, 2, "R3");
    expectConv(16'h2B11, 1'b1, 18, "R3");
    armNow();
    idleCheck(25, "R3");
    burstCode = 2'd0;
    expectConv(16'h0700, 1'b0, 2, "R3");
    expectConv(16'h2B11, 1'b1, 6, "R3");
    armNow();
    idleCheck(12, "R3");

    // Capacity: 9 writes into an 8-deep list (R9)
    pulse(queueClr);
    for (int i = 0; i < 9; i++) writeEntry(16'((i << 8) | (i & 15)));
    for (int i = 0; i < 8; i++)
      expectConv(16'((i << 8) | i), (i == 7), 2 + 4 * i, "R9");
    armNow();
    idleCheck(40, "R9");

    // Queue clear halts a continuous run (R8)
    contMode = 1'b1;
    expectConv(16'h0000, 1'b0, 2, "R8");
    expectConv(16'h0101, 1'b0, 6, "R8");
    armNow();
    waitK(7);
    pulse(queueClr);
    idleCheck(20, "R8");

    // Arm on an empty list is ignored (R10)
    armNow();
    @(negedge clk);
    check(running == 1'b0, "R10", "arm on empty list", running, 0);
    idleCheck(20, "R10");

    // New list after clear, mid source, reload 0 (R8 R4)
    contMode = 1'b0; clkSrc = 2'd2;
    writeEntry(16'h5E8A);
    setPacer(24'd0);
    expectConv(16'h5E8A, 1'b1, 4, "R4");
    armNow();
    idleCheck(15, "R8");

    // External source, reload 1 (R4)
    pulse(queueClr);
    writeEntry(16'h2280);
    setPacer(24'd1);
    clkSrc = 2'd0;
    armNow();
    repeat (20) @(negedge clk);
    check(running == 1'b1, "R4", "waiting on external tick", running, 1);
    pulse(extTick);
    repeat (3) @(negedge clk);
    extTick = 1'b1;
    expectConv(16'h2280, 1'b1, kNow() + 1, "R4");
    @(negedge clk);
    extTick = 1'b0;
    idleCheck(10, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule